// File: doc/BRIEF.md
# Adder-Subtractor ALU with Flags

This block is the arithmetic-logic unit of a small RISC datapath. It is purely combinational. Two operands and a 3-bit operation select come in. Out go a result word and three status flags: zero, unsigned carry and signed overflow. The supported operations are addition, subtraction, bitwise AND, bitwise OR and signed set-less-than.

There is a single ripple carry chain. Subtraction reuses it by inverting the second operand and feeding a carry of one into bit 0. Both the unsigned carry and the signed overflow are taken from that chain. The carry is the carry leaving the top bit. The overflow is the XOR of the carry entering the top bit and the carry leaving it. An equality test is made by subtracting and reading the zero flag. The operand width is a parameter and defaults to 32.

Top module: `addsub_alu`

## Requirements
- R1: With select 010 (ADD) the result is (A + B) modulo 2^WIDTH.
- R2: With select 110 (SUB) the result is (A - B) modulo 2^WIDTH. It is formed as A + ~B + 1.
- R3: For ADD the carry flag is the carry out of the top bit. For SUB and SLT it is the carry out of A + ~B + 1, so it is 1 exactly when A >= B as unsigned numbers.
- R4: For ADD, SUB and SLT the overflow flag is the XOR of the carries into and out of the top bit. At width 4, 0111+0001 and 1000+1111 both set it, while 0011+0001 does not.
- R5: With select 000 (AND) the result is A & B. With select 001 (OR) it is A | B.
- R6: With select 111 (SLT) bit 0 of the result is 1 when A < B as two's-complement numbers and 0 otherwise. All other result bits are 0.
- R7: The zero flag is 1 exactly when every result bit is 0, for every select value.
- R8: For AND, OR and the unused selects 011, 100 and 101, the carry and overflow flags are 0. The unused selects also give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation select: 000 AND, 001 OR, 010 ADD, 110 SUB, 111 SLT |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out of the top bit (arithmetic selects only) |
| ovf_flag | output | 1 | Signed overflow (arithmetic selects only) |

## Verification
A 4-bit instance is swept over every operand pair under all eight select codes. This reaches every sign combination, so each way the two overflow flavours can arise is seen, along with the boundary between carry and no carry and every signed ordering that SLT must resolve. A 32-bit instance gets directed corners and random operands:
- the most negative and most positive values;
- all-ones;
- equal operands, which tell the zero flag apart from a mere non-zero difference.

Together these catch a carry chain that is wrong only in its upper bits.

// File: rtl/addsub_alu_pkg.sv
// Shared operation encoding for the adder-subtractor ALU.
// Assumes: bit 2 of the select means "invert B and carry in one".
package addsub_alu_pkg;
    localparam logic [2:0] OP_AND = 3'b000;
    localparam logic [2:0] OP_OR  = 3'b001;
    localparam logic [2:0] OP_ADD = 3'b010;
    localparam logic [2:0] OP_SUB = 3'b110;
    localparam logic [2:0] OP_SLT = 3'b111;
endpackage

// File: rtl/aa_ripple_adder.sv
// Ripple carry adder that exposes the carries out of the top two bit
// positions, so that the caller can derive the unsigned and signed
// overflow flags. Assumes WIDTH >= 2.
module aa_ripple_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             carry_msb
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    // Full-adder chain, one stage per bit.
    always_comb begin
        chain[0] = carry_in;
        for (int i = 0; i < WIDTH; i++) begin
            sum_out[i]   = a_in[i] ^ b_in[i] ^ chain[i];
            chain[i+1]   = (a_in[i] & b_in[i]) | (chain[i] & (a_in[i] ^ b_in[i]));
        end
    end

    assign carry_out = chain[WIDTH];
    assign carry_msb = chain[MSB];

    // Checks the chain against wide arithmetic and the sign-rule overflow.
    always_comb begin
        if (!$isunknown({a_in, b_in, carry_in})) begin
            assert_sum_matches_R1: assert ({carry_out, sum_out} ==
                ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
                else $error("ripple chain disagrees with wide sum");
            assert_ovf_sign_rule_R4: assert ((carry_out ^ carry_msb) ==
                ((a_in[MSB] == b_in[MSB]) && (sum_out[MSB] != a_in[MSB])))
                else $error("carry xor does not match sign rule");
        end
    end
endmodule

// File: rtl/aa_bitwise_unit.sv
// Bitwise AND and OR of the two operands, side by side.
// Assumes nothing beyond equal operand widths.
module aa_bitwise_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out
);
    // Per-bit logic functions.
    always_comb begin
        and_out = a_in & b_in;
        or_out  = a_in | b_in;
    end

    // AND never exceeds either input; OR always covers both.
    always_comb begin
        if (!$isunknown({a_in, b_in})) begin
            assert_logic_bounds_R5: assert (((and_out & ~b_in) == '0) &&
                                            ((a_in & ~or_out) == '0))
                else $error("bitwise unit outputs out of bounds");
        end
    end
endmodule

// File: rtl/addsub_alu.sv
// Combinational ALU with one shared adder. Subtraction and SLT invert B
// and inject carry-in one. The flags come from the carry chain. The zero
// flag covers every select, while carry and overflow are forced low for
// non-arithmetic selects. Assumes WIDTH >= 2; there is no state.
module addsub_alu
    import addsub_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             carry_flag,
    output logic             ovf_flag
);
    localparam int MSB = WIDTH - 1;

    logic             do_invert;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum_w;
    logic             c_top;
    logic             c_into_top;
    logic             ovf_raw;
    logic             is_arith;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;

    // Operand conditioning for subtraction through the adder.
    always_comb begin
        do_invert = op_sel[2];
        b_eff     = do_invert ? ~opnd_b : opnd_b;
    end

    aa_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a_in      (opnd_a),
        .b_in      (b_eff),
        .carry_in  (do_invert),
        .sum_out   (sum_w),
        .carry_out (c_top),
        .carry_msb (c_into_top)
    );

    aa_bitwise_unit #(.WIDTH(WIDTH)) u_logic (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .and_out (and_w),
        .or_out  (or_w)
    );

    assign ovf_raw = c_top ^ c_into_top;

    // Result selection by operation code.
    always_comb begin
        result   = '0;
        is_arith = 1'b0;
        case (op_sel)
            OP_AND: result = and_w;
            OP_OR:  result = or_w;
            OP_ADD: begin result = sum_w; is_arith = 1'b1; end
            OP_SUB: begin result = sum_w; is_arith = 1'b1; end
            OP_SLT: begin
                result[0] = sum_w[MSB] ^ ovf_raw;
                is_arith  = 1'b1;
            end
            default: result = '0;
        endcase
    end

    // Status flags.
    always_comb begin
        zero_flag  = (result == '0);
        carry_flag = is_arith & c_top;
        ovf_flag   = is_arith & ovf_raw;
    end

    // Operation-level checks against plain arithmetic.
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (op_sel == OP_SUB) begin
                assert_sub_diff_R2: assert (result == opnd_a - opnd_b)
                    else $error("subtraction result wrong");
            end
            if (op_sel == OP_ADD) begin
                assert_add_carry_R3: assert (carry_flag ==
                    (({1'b0, opnd_a} + {1'b0, opnd_b}) >> WIDTH))
                    else $error("add carry wrong");
            end
            if (op_sel == OP_SLT) begin
                assert_slt_shape_R6: assert ((result[MSB:1] == '0) &&
                    (result[0] == ($signed(opnd_a) < $signed(opnd_b))))
                    else $error("slt result wrong");
            end
            if (op_sel inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b101}) begin
                assert_no_flags_R8: assert (!carry_flag && !ovf_flag)
                    else $error("flag raised on non-arithmetic select");
            end
            if (op_sel inside {3'b011, 3'b100, 3'b101}) begin
                assert_unused_zero_R8: assert ((result == '0) && zero_flag)
                    else $error("unused select gave non-zero result");
            end
        end
    end
endmodule

// File: tb/tb_addsub_alu.sv
module tb_addsub_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W_SMALL    = 4;
    localparam int W_WIDE     = 32;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [W_SMALL-1:0] a4, b4, r4;
    logic [2:0]         op4;
    logic               z4, c4, v4;
    logic [W_WIDE-1:0]  a32, b32, r32;
    logic [2:0]         op32;
    logic               z32, c32, v32;

    addsub_alu #(.WIDTH(W_SMALL)) dut (
        .opnd_a(a4), .opnd_b(b4), .op_sel(op4),
        .result(r4), .zero_flag(z4), .carry_flag(c4), .ovf_flag(v4)
    );

    addsub_alu #(.WIDTH(W_WIDE)) dut_wide (
        .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
        .result(r32), .zero_flag(z32), .carry_flag(c32), .ovf_flag(v32)
    );

    function automatic longint sx(input int w, input longint unsigned x);
        longint unsigned half = 64'd1 << (w - 1);
        return (x >= half) ? longint'(x) - longint'(half << 1) : longint'(x);
    endfunction

    function automatic string tags(input logic [2:0] op);
        case (op)
            3'b010:  return "R1 R3 R4 R7";
            3'b110:  return "R2 R3 R4 R7";
            3'b111:  return "R6 R3 R4 R7";
            3'b000, 3'b001: return "R5 R7 R8";
            default: return "R8 R7";
        endcase
    endfunction

    // Reference model computed from the requirements.
    task automatic ref_model(input int w, input longint unsigned a, input longint unsigned b,
                             input logic [2:0] op, output longint unsigned res,
                             output logic z, output logic c, output logic v);
        longint unsigned mask = (64'd1 << w) - 1;
        longint smax = longint'((64'd1 << (w - 1)) - 1);
        longint smin = -smax - 1;
        longint sa = sx(w, a);
        longint sb = sx(w, b);
        res = 0; c = 0; v = 0;
        case (op)
            3'b000: res = a & b;
            3'b001: res = a | b;
            3'b010: begin
                res = (a + b) & mask;
                c = ((a + b) >> w) != 0;
                v = (sa + sb > smax) || (sa + sb < smin);
            end
            3'b110, 3'b111: begin
                res = (op == 3'b110) ? ((a - b) & mask) : ((sa < sb) ? 1 : 0);
                c = (a >= b);
                v = (sa - sb > smax) || (sa - sb < smin);
            end
            default: res = 0;
        endcase
        z = (res == 0);
    endtask

    task automatic compare(input int w, input string note, input logic [2:0] op,
                           input longint unsigned a, input longint unsigned b,
                           input longint unsigned ar, input logic az,
                           input logic ac, input logic av);
        longint unsigned er;
        logic ez, ec, ev;
        ref_model(w, a, b, op, er, ez, ec, ev);
        n_checks++;
        if (ar !== er || az !== ez || ac !== ec || av !== ev) begin
            n_fails++;
            $display("FAIL %s %s w=%0d op=%b a=%h b=%h: got r=%h z=%b c=%b v=%b, expected r=%h z=%b c=%b v=%b",
                     tags(op), note, w, op, a, b, ar, az, ac, av, er, ez, ec, ev);
        end
    endtask

    task automatic run4(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                        input string note);
        @(negedge clk);
        op4 = op; a4 = a; b4 = b;
        @(posedge clk);
        #1;
        compare(W_SMALL, note, op, a, b, r4, z4, c4, v4);
    endtask

    task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input string note);
        @(negedge clk);
        op32 = op; a32 = a; b32 = b;
        @(posedge clk);
        #1;
        compare(W_WIDE, note, op, a, b, r32, z32, c32, v32);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        a4 = '0; b4 = '0; op4 = 3'b000;
        a32 = '0; b32 = '0; op32 = 3'b000;
        // Idle inputs: all-zero operands give a zero result (R7).
        run4(3'b010, 4'h0, 4'h0, "R7 idle zero");
        // Named overflow corners (R4).
        run4(3'b010, 4'b0111, 4'b0001, "R4 positive overflow");
        run4(3'b010, 4'b1000, 4'b1111, "R4 negative overflow");
        run4(3'b010, 4'b0011, 4'b0001, "R4 no overflow");
        run4(3'b110, 4'b0101, 4'b0101, "R2 R7 equality via subtract");
        run4(3'b111, 4'b1000, 4'b0111, "R6 min below max");
        run4(3'b101, 4'hF, 4'hF, "R8 unused select");
        // Exhaustive sweep of the small instance over all selects.
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(op[2:0], a[3:0], b[3:0], "sweep");
        // Wide corners.
        for (int op = 0; op < 8; op++) begin
            run32(op[2:0], 32'h7FFF_FFFF, 32'h0000_0001, "corner max+1");
            run32(op[2:0], 32'h8000_0000, 32'hFFFF_FFFF, "corner min,-1");
            run32(op[2:0], 32'hFFFF_FFFF, 32'h0000_0001, "corner all-ones");
            run32(op[2:0], 32'h8000_0000, 32'h8000_0000, "corner min,min");
            run32(op[2:0], 32'h1234_5678, 32'h1234_5678, "corner equal");
            run32(op[2:0], 32'h0000_0000, 32'h8000_0000, "corner 0,min");
        end
        // Wide random operands under the defined selects.
        for (int k = 0; k < 300; k++) begin
            logic [2:0] ops [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
            run32(ops[k % 5], $urandom, $urandom, "random");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule